// File: doc/BRIEF.md
# Channel Digital Reset Sequencer

This block drives the digital resets of one transceiver channel. Each edge of those resets goes through a shared reset arbiter by a request/acknowledge handshake. The transmit and receive directions each have their own sequencer. A single command pulse on a direction starts a full cycle made of two handshakes. In the first handshake the die-to-die link reset, the FEC reset and the PMA-interface reset are driven high. In the second handshake they are released. After that the direction reports that it is done.

A request is raised only while that direction's PMA reports ready. The receive release request also waits until the lock-to-data flag has been high without a break for a fixed time, given as the clock frequency times a hold time in microseconds. When the FEC is in use, the two directions never overlap: a transmit cycle finishes completely before any receive cycle begins. All pins are plain control and status levels or pulses. The block carries no data stream, so there is no back-pressure.

Top module: `chan_rst_seq`

## Requirements
- R1: While `rst` is high, and on the first edge after it rises, both requests and both done flags are low and all six channel reset outputs are high.
- R2: Each command runs two handshakes. In the first, the three resets of that direction go high. In the second, they go low. The resets change only on the edge after the direction's request and acknowledge are both sampled high.
- R3: A request rises only on the edge after that direction's PMA-ready input is sampled high while the sequencer is waiting to request.
- R4: A request drops on the edge after its resets change. No new request of that direction is raised until its acknowledge has been sampled low.
- R5: The receive release request is raised only after `rx_lock` has been sampled high on at least CLK_MHZ*LOCK_US consecutive edges. Any low sample restarts that count from zero.
- R6: With USE_FEC=1, a receive cycle does not start while a transmit cycle is running or pending. If both commands are pending, transmit goes first. A transmit cycle waits for a running receive cycle to finish. Because of this, `tx_req` and `rx_req` are never high together.
- R7: A direction's done flag goes high on the edge after its acknowledge is sampled low in the release handshake. It is cleared when a new command for that direction is accepted.
- R8: A command pulse that arrives while its direction is running is ignored. A command on an idle direction that is held back by the ordering rule of R6 is remembered until it can start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_pma_rdy | input | 1 | Transmit PMA ready |
| rx_pma_rdy | input | 1 | Receive PMA ready |
| rx_lock | input | 1 | Receiver locked to data |
| tx_cmd | input | 1 | Pulse: start a transmit reset cycle |
| rx_cmd | input | 1 | Pulse: start a receive reset cycle |
| tx_ack | input | 1 | Arbiter grant for the transmit request |
| rx_ack | input | 1 | Arbiter grant for the receive request |
| tx_req | output | 1 | Transmit request to the arbiter |
| rx_req | output | 1 | Receive request to the arbiter |
| tx_d2d_rst | output | 1 | Transmit die-to-die link reset |
| tx_fec_rst | output | 1 | Transmit FEC reset |
| tx_pif_rst | output | 1 | Transmit PMA-interface reset |
| rx_d2d_rst | output | 1 | Receive die-to-die link reset |
| rx_fec_rst | output | 1 | Receive FEC reset |
| rx_pif_rst | output | 1 | Receive PMA-interface reset |
| tx_done | output | 1 | Transmit cycle complete |
| rx_done | output | 1 | Receive cycle complete |

## Verification
Every output is a register, so each result is due exactly one edge after the input that causes it is sampled:
- a request, one edge after PMA-ready (and, for a receive release, lock qualification) is sampled;
- the resets, one edge after the acknowledge;
- the request drop, one edge after the resets change;
- the done flag, one edge after the acknowledge is sampled low.

The bench has a behavioural model and a small arbiter that grants three cycles after a request. The model steps on the same rising edge as the design. Both are compared on the following falling edge, so every expected value is read in the cycle it is due.

Directed waits cover the cases where an output must stay unchanged: a request must stay low while PMA-ready is low, while a lock run has been broken, or while the acknowledge is held high. For these, the waits run longer than the design could take to act, and the bench then checks the request at the ports.

// File: rtl/rst_seq_pkg.sv
package rst_seq_pkg;
  localparam int DIRS   = 2;
  localparam int TX_IDX = 0;
  localparam int RX_IDX = 1;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_ARM_SET,
    PH_WAIT_SET,
    PH_HOLD_SET,
    PH_DRAIN_SET,
    PH_ARM_CLR,
    PH_WAIT_CLR,
    PH_HOLD_CLR,
    PH_DRAIN_CLR
  } phase_t;
endpackage

// File: rtl/lock_qual.sv
module lock_qual #(
  parameter int HOLD_CYCLES = 22500
) (
  input  logic clk,
  input  logic rst,
  input  logic lock,
  output logic ok
);
  localparam int W = $clog2(HOLD_CYCLES + 1);
  localparam logic [W-1:0] LIMIT = W'(HOLD_CYCLES);

  logic [W-1:0] run_q;

  // count consecutive high samples, saturate at the limit, clear on any low
  always_ff @(posedge clk) begin
    if (rst || !lock) run_q <= '0;
    else if (run_q != LIMIT) run_q <= run_q + 1'b1;
  end

  assign ok = (run_q == LIMIT);
endmodule

// File: rtl/launch_gate.sv
module launch_gate import rst_seq_pkg::*; #(
  parameter bit ORDERED = 1'b1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DIRS-1:0] cmd,
  input  logic [DIRS-1:0] idle,
  output logic [DIRS-1:0] launch
);
  logic [DIRS-1:0] pend_q, eff, allow;

  // a command counts only while its direction is idle
  assign eff = pend_q | (cmd & idle);

  always_comb begin
    allow = '1;
    if (ORDERED) begin
      allow[TX_IDX] = idle[RX_IDX];
      allow[RX_IDX] = idle[TX_IDX] && !eff[TX_IDX];
    end
  end

  assign launch = eff & allow;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= eff & ~launch;
  end
endmodule

// File: rtl/dir_fsm.sv
module dir_fsm import rst_seq_pkg::*; (
  input  logic clk,
  input  logic rst,
  input  logic launch,
  input  logic pma_rdy,
  input  logic may_release,
  input  logic ack,
  output logic req,
  output logic chan_rst,
  output logic done,
  output logic idle
);
  phase_t ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      req      <= 1'b0;
      chan_rst <= 1'b1;
      done     <= 1'b0;
    end else begin
      unique case (ph)
        PH_IDLE: if (launch) begin
          ph   <= PH_ARM_SET;
          done <= 1'b0;
        end
        PH_ARM_SET: if (pma_rdy) begin
          req <= 1'b1;
          ph  <= PH_WAIT_SET;
        end
        PH_WAIT_SET: if (ack) begin
          chan_rst <= 1'b1;
          ph       <= PH_HOLD_SET;
        end
        PH_HOLD_SET: begin
          req <= 1'b0;
          ph  <= PH_DRAIN_SET;
        end
        PH_DRAIN_SET: if (!ack) ph <= PH_ARM_CLR;
        PH_ARM_CLR: if (pma_rdy && may_release) begin
          req <= 1'b1;
          ph  <= PH_WAIT_CLR;
        end
        PH_WAIT_CLR: if (ack) begin
          chan_rst <= 1'b0;
          ph       <= PH_HOLD_CLR;
        end
        PH_HOLD_CLR: begin
          req <= 1'b0;
          ph  <= PH_DRAIN_CLR;
        end
        PH_DRAIN_CLR: if (!ack) begin
          done <= 1'b1;
          ph   <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign idle = (ph == PH_IDLE);
endmodule

// File: rtl/chan_rst_seq.sv
module chan_rst_seq import rst_seq_pkg::*; #(
  parameter int CLK_MHZ = 125,
  parameter int LOCK_US = 180,
  parameter bit USE_FEC = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_pma_rdy,
  input  logic rx_pma_rdy,
  input  logic rx_lock,
  input  logic tx_cmd,
  input  logic rx_cmd,
  input  logic tx_ack,
  input  logic rx_ack,
  output logic tx_req,
  output logic rx_req,
  output logic tx_d2d_rst,
  output logic tx_fec_rst,
  output logic tx_pif_rst,
  output logic rx_d2d_rst,
  output logic rx_fec_rst,
  output logic rx_pif_rst,
  output logic tx_done,
  output logic rx_done
);
  localparam int HOLD = CLK_MHZ * LOCK_US;

  logic [DIRS-1:0] cmd_v, pma_v, ack_v, rel_v, launch_v, idle_v, req_v, rst_v, done_v;
  logic            lock_ok;

  assign cmd_v = {rx_cmd, tx_cmd};
  assign pma_v = {rx_pma_rdy, tx_pma_rdy};
  assign ack_v = {rx_ack, tx_ack};
  assign rel_v = {lock_ok, 1'b1};

  lock_qual #(.HOLD_CYCLES(HOLD)) u_lock (
    .clk (clk),
    .rst (rst),
    .lock(rx_lock),
    .ok  (lock_ok)
  );

  launch_gate #(.ORDERED(USE_FEC)) u_gate (
    .clk   (clk),
    .rst   (rst),
    .cmd   (cmd_v),
    .idle  (idle_v),
    .launch(launch_v)
  );

  for (genvar g = 0; g < DIRS; g++) begin : g_dir
    dir_fsm u_fsm (
      .clk        (clk),
      .rst        (rst),
      .launch     (launch_v[g]),
      .pma_rdy    (pma_v[g]),
      .may_release(rel_v[g]),
      .ack        (ack_v[g]),
      .req        (req_v[g]),
      .chan_rst   (rst_v[g]),
      .done       (done_v[g]),
      .idle       (idle_v[g])
    );
  end

  assign tx_req     = req_v[TX_IDX];
  assign rx_req     = req_v[RX_IDX];
  assign tx_d2d_rst = rst_v[TX_IDX];
  assign tx_fec_rst = rst_v[TX_IDX];
  assign tx_pif_rst = rst_v[TX_IDX];
  assign rx_d2d_rst = rst_v[RX_IDX];
  assign rx_fec_rst = rst_v[RX_IDX];
  assign rx_pif_rst = rst_v[RX_IDX];
  assign tx_done    = done_v[TX_IDX];
  assign rx_done    = done_v[RX_IDX];
endmodule

// File: rtl/chan_rst_seq_chk.sv
module chan_rst_seq_chk #(
  parameter int CLK_MHZ = 125,
  parameter int LOCK_US = 180,
  parameter bit USE_FEC = 1'b1
) (
  input logic clk,
  input logic rst,
  input logic tx_pma_rdy,
  input logic rx_pma_rdy,
  input logic rx_lock,
  input logic tx_ack,
  input logic rx_ack,
  input logic tx_req,
  input logic rx_req,
  input logic tx_d2d_rst,
  input logic rx_d2d_rst
);
  localparam int HOLD = CLK_MHZ * LOCK_US;

  int   lk_run;
  logic rx_req_q, rx_second;

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_run    <= 0;
      rx_req_q  <= 1'b0;
      rx_second <= 1'b0;
    end else begin
      lk_run   <= !rx_lock ? 0 : (lk_run < HOLD ? lk_run + 1 : lk_run);
      rx_req_q <= rx_req;
      if (rx_req && !rx_req_q) rx_second <= !rx_second;
    end
  end

  assert_tx_req_pma_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_req) |-> $past(tx_pma_rdy));
  assert_rx_req_pma_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_req) |-> $past(rx_pma_rdy));
  assert_tx_edge_on_ack_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(tx_d2d_rst) |-> $past(tx_req && tx_ack));
  assert_rx_edge_on_ack_R2: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_d2d_rst) |-> $past(rx_req && rx_ack));
  assert_tx_drop_after_edge_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(tx_d2d_rst) |=> !tx_req);
  assert_rx_drop_after_edge_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_d2d_rst) |=> !rx_req);
  assert_rx_release_lock_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(rx_req) && rx_second) |-> ($past(lk_run) >= HOLD));
  assert_fec_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
    !(USE_FEC && tx_req && rx_req));
endmodule

bind chan_rst_seq chan_rst_seq_chk #(
  .CLK_MHZ(CLK_MHZ), .LOCK_US(LOCK_US), .USE_FEC(USE_FEC)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tx_pma_rdy(tx_pma_rdy),
  .rx_pma_rdy(rx_pma_rdy),
  .rx_lock   (rx_lock),
  .tx_ack    (tx_ack),
  .rx_ack    (rx_ack),
  .tx_req    (tx_req),
  .rx_req    (rx_req),
  .tx_d2d_rst(tx_d2d_rst),
  .rx_d2d_rst(rx_d2d_rst)
);

// File: tb/chan_rst_seq_test.sv
module chan_rst_seq_test;
  localparam int CLK_MHZ = 125;
  localparam int LOCK_US = 2;
  localparam int NQ      = CLK_MHZ * LOCK_US;
  localparam int ACK_DLY = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, tx_pma_rdy, rx_pma_rdy, rx_lock, tx_cmd, rx_cmd;
  logic tx_req, rx_req, tx_d2d_rst, tx_fec_rst, tx_pif_rst;
  logic rx_d2d_rst, rx_fec_rst, rx_pif_rst, tx_done, rx_done;
  logic [1:0] ackv = 2'b00;

  chan_rst_seq #(.CLK_MHZ(CLK_MHZ), .LOCK_US(LOCK_US), .USE_FEC(1'b1)) uut (
    .clk(clk), .rst(rst), .tx_pma_rdy(tx_pma_rdy), .rx_pma_rdy(rx_pma_rdy),
    .rx_lock(rx_lock), .tx_cmd(tx_cmd), .rx_cmd(rx_cmd),
    .tx_ack(ackv[0]), .rx_ack(ackv[1]), .tx_req(tx_req), .rx_req(rx_req),
    .tx_d2d_rst(tx_d2d_rst), .tx_fec_rst(tx_fec_rst), .tx_pif_rst(tx_pif_rst),
    .rx_d2d_rst(rx_d2d_rst), .rx_fec_rst(rx_fec_rst), .rx_pif_rst(rx_pif_rst),
    .tx_done(tx_done), .rx_done(rx_done)
  );

  int n_run = 0, n_fail = 0;
  bit cmp_en = 1'b0;
  bit hold_ack[2];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  // arbiter stand-in: grant ACK_DLY cycles after a request, drop when request drops
  int wt[2];
  always @(negedge clk) begin
    logic [1:0] rq;
    rq = {rx_req, tx_req};
    for (int d = 0; d < 2; d++) begin
      if (rq[d] === 1'b1) begin
        if (!ackv[d]) begin
          wt[d]++;
          if (wt[d] >= ACK_DLY) ackv[d] = 1'b1;
        end
      end else begin
        wt[d] = 0;
        if (!hold_ack[d]) ackv[d] = 1'b0;
      end
    end
  end

  // behavioural reference: step index per direction, pending flags, lock run
  int ph[2];
  bit mp[2], mreq[2], mrst[2], mdone[2];
  int lk;
  always @(posedge clk) begin
    bit q;
    bit ep[2], al[2], ln[2], cm[2], pm[2];
    if (rst) begin
      for (int d = 0; d < 2; d++) begin
        ph[d] = 0; mp[d] = 0; mreq[d] = 0; mrst[d] = 1; mdone[d] = 0;
      end
      lk = 0;
    end else begin
      q = (lk >= NQ);
      if (!rx_lock) lk = 0; else if (lk < NQ) lk++;
      cm[0] = tx_cmd; cm[1] = rx_cmd; pm[0] = tx_pma_rdy; pm[1] = rx_pma_rdy;
      for (int d = 0; d < 2; d++) ep[d] = mp[d] | (cm[d] & (ph[d] == 0));
      al[0] = (ph[1] == 0);
      al[1] = (ph[0] == 0) && !ep[0];
      for (int d = 0; d < 2; d++) begin
        ln[d] = ep[d] & al[d];
        mp[d] = ep[d] & !ln[d];
        case (ph[d])
          0: if (ln[d]) begin ph[d] = 1; mdone[d] = 0; end
          1: if (pm[d]) begin mreq[d] = 1; ph[d] = 2; end
          2: if (ackv[d]) begin mrst[d] = 1; ph[d] = 3; end
          3: begin mreq[d] = 0; ph[d] = 4; end
          4: if (!ackv[d]) ph[d] = 5;
          5: if (pm[d] && (d == 0 || q)) begin mreq[d] = 1; ph[d] = 6; end
          6: if (ackv[d]) begin mrst[d] = 0; ph[d] = 7; end
          7: begin mreq[d] = 0; ph[d] = 8; end
          default: if (!ackv[d]) begin mdone[d] = 1; ph[d] = 0; end
        endcase
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_en) begin
      check({rx_req, tx_req} == {mreq[1], mreq[0]}, "R3 request",
            int'({rx_req, tx_req}), int'({mreq[1], mreq[0]}));
      check({rx_d2d_rst, rx_fec_rst, rx_pif_rst, tx_d2d_rst, tx_fec_rst, tx_pif_rst}
            == {{3{mrst[1]}}, {3{mrst[0]}}}, "R2 resets",
            int'({rx_d2d_rst, rx_fec_rst, rx_pif_rst, tx_d2d_rst, tx_fec_rst, tx_pif_rst}),
            int'({{3{mrst[1]}}, {3{mrst[0]}}}));
      check({rx_done, tx_done} == {mdone[1], mdone[0]}, "R7 done",
            int'({rx_done, tx_done}), int'({mdone[1], mdone[0]}));
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL R7 watchdog actual=0 expected=1");
    finish_run();
  end

  task automatic pulse(input bit tx, input bit rx);
    @(negedge clk); tx_cmd = tx; rx_cmd = rx;
    @(negedge clk); tx_cmd = 0; rx_cmd = 0;
  endtask

  task automatic wait_done(input int d, input string tag);
    int t = 0;
    while (!(d == 0 ? tx_done : rx_done) && t < 5000) begin @(negedge clk); t++; end
    check((d == 0 ? tx_done : rx_done), tag, 0, 1);
  endtask

  task automatic check_reset_state(input string tag);
    check({tx_req, rx_req, tx_done, rx_done} == 4'b0000, tag,
          int'({tx_req, rx_req, tx_done, rx_done}), 0);
    check({tx_d2d_rst, tx_fec_rst, tx_pif_rst, rx_d2d_rst, rx_fec_rst, rx_pif_rst} == 6'h3f,
          tag, int'({tx_d2d_rst, tx_fec_rst, tx_pif_rst, rx_d2d_rst, rx_fec_rst, rx_pif_rst}), 63);
  endtask

  initial begin
    bit early;
    rst = 1; tx_pma_rdy = 0; rx_pma_rdy = 0; rx_lock = 0; tx_cmd = 0; rx_cmd = 0;
    hold_ack[0] = 0; hold_ack[1] = 0;
    repeat (4) @(negedge clk);
    check_reset_state("R1 after reset");
    rst = 0; cmp_en = 1;
    tx_pma_rdy = 1; rx_pma_rdy = 1; rx_lock = 1;

    // R2/R7: a plain transmit cycle
    pulse(1, 0);
    wait_done(0, "R7 tx done");
    check(tx_d2d_rst == 0, "R2 tx released", tx_d2d_rst, 0);

    // R6: both commands together, receive must wait for transmit
    pulse(1, 1);
    early = 0;
    for (int t = 0; t < 3000 && !rx_done; t++) begin
      @(negedge clk);
      if (rx_req && !tx_done) early = 1;
    end
    check(!early, "R6 rx before tx done", early, 0);
    check(rx_done && tx_done, "R6 both done", int'({rx_done, tx_done}), 3);

    // R3: no receive request while its PMA is not ready
    rx_pma_rdy = 0;
    pulse(0, 1);
    repeat (20) @(negedge clk);
    check(rx_req == 0, "R3 rx held by pma", rx_req, 0);
    rx_pma_rdy = 1;
    wait_done(1, "R7 rx done");

    // R5: broken lock run delays the release request
    rx_lock = 0;
    pulse(0, 1);
    repeat (40) @(negedge clk);
    check(rx_req == 0 && rx_d2d_rst == 1, "R5 no release without lock",
          int'({rx_req, rx_d2d_rst}), 1);
    rx_lock = 1;
    repeat (NQ / 2) @(negedge clk);
    rx_lock = 0;
    @(negedge clk);
    rx_lock = 1;
    repeat (NQ - 5) @(negedge clk);
    check(rx_req == 0, "R5 lock run restarted", rx_req, 0);
    wait_done(1, "R5 rx done after lock");

    // R8: a second command during a running cycle is dropped
    pulse(0, 1);
    repeat (3) @(negedge clk);
    pulse(0, 1);
    wait_done(1, "R8 rx done");
    repeat (30) @(negedge clk);
    check(rx_req == 0 && rx_done == 1, "R8 busy command ignored",
          int'({rx_req, rx_done}), 1);

    // R4: acknowledge held high keeps the next request down
    hold_ack[0] = 1;
    pulse(1, 0);
    for (int t = 0; t < 200 && !tx_req; t++) @(negedge clk);
    for (int t = 0; t < 200 && tx_req; t++) @(negedge clk);
    repeat (20) @(negedge clk);
    check(tx_req == 0 && tx_d2d_rst == 1, "R4 wait for ack low",
          int'({tx_req, tx_d2d_rst}), 1);
    hold_ack[0] = 0;
    wait_done(0, "R4 tx done");

    // R1: reset in the middle of a cycle
    pulse(1, 0);
    repeat (6) @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    check_reset_state("R1 mid-cycle reset");
    rst = 0;
    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule